// File: doc/BRIEF.md
# Inter-Access Wait Sequencer for a Static Memory Controller

This block sits in front of the bus timing engine of a static memory controller that serves several chip selects. For each new request it decides how many idle cycles must pass before the access may start, then grants it through a valid/ready handshake. It combines four kinds of gap:

- a one-cycle gap when the chip select changes;
- a one-cycle gap that absorbs a pending configuration reload;
- a one-cycle gap from a read to a following write;
- a per-device data-float gap that lets a slow device release the data bus after a read.

Some of these add together and some overlap. The timing engine reports the end of each transfer with a one-cycle `xfer_done` pulse. A mode-register write loads the chip select's float count and float-mode enable. A change of the slow-clock level marks a reload as pending. When a pending reload is taken up, the block pulses `reload_pulse` so that the engine latches its new parameters. Requests to internal memory pass through at once.

Top module: `mem_gap_sequencer`

## Requirements
- R1: After reset no reload is pending, all float counts are zero and there is no previous access. The first external request is granted in the cycle it is first presented, and `reload_pulse` is 0.
- R2: A write to the mode register of any chip select (`cfg_mode_wr`) makes a reload pending. A write that touches only timing registers (`cfg_timing_wr`) does not, so it adds no wait cycle.
- R3: When a reload is pending and the request targets the same chip select as the previous external access, one wait cycle is inserted. This holds even if the rewritten chip select was a different one.
- R4: When a reload is pending and the request targets a different chip select, exactly one wait cycle is inserted in total. The chip-select change and the reload share that cycle.
- R5: A change of chip select with no reload pending costs one wait cycle. An access to the same chip select with nothing else outstanding costs none.
- R6: A write that follows a read costs one extra wait cycle. This cycle adds to any chip-select or reload cycle: 1 on the same chip select, 2 across chip selects.
- R7: A change in the level of `slow_mode` makes a reload pending. While a transfer is in progress the reload is not taken up; it is taken up in the wait cycle before the next access.
- R8: After a read from chip select c ends, the next external access waits until N cycles have passed since `xfer_done`, where N is the 4-bit float count of c. This applies when the next access is a write, or a read to a different chip select. Cycles spent on other gaps count toward N, so the gap is the larger of the two.
- R9: After a read, a read to the same chip select waits for the float count only when that chip select's float-mode enable is set. When the enable is clear it waits for none.
- R10: An internal request (`req_internal`=1) is granted in the cycle it is presented, whether or not a float count, a transfer or a reload is outstanding. It does not become the previous access.
- R11: Between the grant of an external access and its `xfer_done`, `req_ready` stays low for external requests.
- R12: `reload_pulse` is high for exactly one cycle for each reload taken up. That cycle is a wait cycle in which the request is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cs | input | CSW | Target chip select |
| req_write | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | Request to internal memory |
| req_ready | output | 1 | Grant; an access starts on valid and ready |
| xfer_done | input | 1 | One-cycle pulse at the end of the external transfer |
| cfg_mode_wr | input | 1 | Mode register write strobe |
| cfg_timing_wr | input | 1 | Timing register write strobe (no reload) |
| cfg_cs | input | CSW | Chip select of the mode write |
| cfg_float_cycles | input | FLOAT_W | Float count loaded on a mode write |
| cfg_float_mode | input | 1 | Float-mode enable loaded on a mode write |
| slow_mode | input | 1 | Slow-clock mode level |
| reload_pulse | output | 1 | Parameter reload strobe |

## Verification
`req_ready` and `reload_pulse` are combinational from the request and the registered state. The bench therefore drives a request just after a falling edge and samples both outputs 1 ns later, once in each cycle, until the grant appears. The gap is the number of cycles in which the request was presented and not granted. A float count is loaded at the rising edge on which `xfer_done` is high, and every later access is presented in the next cycle. The expected gap is then the larger of N and the other gaps, counted from that first presented cycle. When an internal access comes between, the expected gap drops by the one cycle that access used.

// File: rtl/mem_gap_sequencer.sv
module mem_gap_sequencer #(
  parameter int NUM_CS  = 4,
  parameter int FLOAT_W = 4,
  localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CSW-1:0]     req_cs,
  input  logic               req_write,
  input  logic               req_internal,
  output logic               req_ready,
  input  logic               xfer_done,
  input  logic               cfg_mode_wr,
  input  logic               cfg_timing_wr,
  input  logic [CSW-1:0]     cfg_cs,
  input  logic [FLOAT_W-1:0] cfg_float_cycles,
  input  logic               cfg_float_mode,
  input  logic               slow_mode,
  output logic               reload_pulse
);

  logic [FLOAT_W-1:0] flt_cnt [NUM_CS];
  logic [NUM_CS-1:0]  flt_mode;
  logic [FLOAT_W-1:0] fcnt;
  logic               pending, rl_taken, busy, slow_q;
  logic               prev_valid, prev_read, cur_read;
  logic [CSW-1:0]     prev_cs, cur_cs;
  logic [1:0]         waited;

  logic       ext_wait, cs_change, rw_gap, rl_due, flt_apply, flt_block, ext_go, slow_chg;
  logic [1:0] need;

  assign ext_wait  = req_valid & ~req_internal & ~busy;
  assign cs_change = prev_valid & (req_cs != prev_cs);
  assign rw_gap    = prev_valid & prev_read & req_write;
  assign rl_due    = pending & ~rl_taken;
  assign need      = {1'b0, cs_change | rl_taken} + {1'b0, rw_gap};
  assign flt_apply = prev_valid & prev_read & (req_write | cs_change | flt_mode[prev_cs]);
  assign flt_block = flt_apply & (fcnt != '0);
  assign ext_go    = ext_wait & ~rl_due & (waited >= need) & ~flt_block;
  assign slow_chg  = slow_mode ^ slow_q;

  assign req_ready    = req_internal ? 1'b1 : ext_go;
  assign reload_pulse = ext_wait & rl_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) flt_cnt[i] <= '0;
      flt_mode   <= '0;
      fcnt       <= '0;
      pending    <= 1'b0;
      rl_taken   <= 1'b0;
      busy       <= 1'b0;
      slow_q     <= 1'b0;
      prev_valid <= 1'b0;
      prev_read  <= 1'b0;
      prev_cs    <= '0;
      cur_read   <= 1'b0;
      cur_cs     <= '0;
      waited     <= '0;
    end else begin
      slow_q <= slow_mode;

      if (cfg_mode_wr) begin
        flt_cnt[cfg_cs]  <= cfg_float_cycles;
        flt_mode[cfg_cs] <= cfg_float_mode;
      end

      if (cfg_mode_wr | slow_chg) pending <= 1'b1;
      else if (reload_pulse)      pending <= 1'b0;

      if (ext_go)            rl_taken <= 1'b0;
      else if (reload_pulse) rl_taken <= 1'b1;

      if (req_valid & req_ready)         waited <= '0;
      else if (ext_wait && waited != 2'd3) waited <= waited + 2'd1;

      if (ext_go) begin
        busy       <= 1'b1;
        prev_valid <= 1'b1;
        prev_cs    <= req_cs;
        prev_read  <= ~req_write;
        cur_cs     <= req_cs;
        cur_read   <= ~req_write;
      end else if (xfer_done) begin
        busy <= 1'b0;
      end

      if (busy & xfer_done & cur_read) fcnt <= flt_cnt[cur_cs];
      else if (fcnt != '0)             fcnt <= fcnt - 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reload_pulse); // R12
  AST_PULSE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> !req_ready); // R12
  AST_INTERNAL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_internal) |-> req_ready); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(req_ready && !req_internal)); // R11
  AST_TIMING_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_timing_wr && !cfg_mode_wr && !slow_chg && !pending) |=> !pending); // R2
  AST_MODE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_wr |=> pending); // R2
  AST_FLOAT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_internal && req_ready && prev_valid && prev_read && req_write) |-> (fcnt == '0)); // R8

endmodule

// File: tb/tb_mem_gap_sequencer.sv
`timescale 1ns/1ps
module tb_mem_gap_sequencer;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_internal = 0, req_ready;
  logic [1:0] req_cs = 0, cfg_cs = 0;
  logic xfer_done = 0, cfg_mode_wr = 0, cfg_timing_wr = 0, cfg_float_mode = 0, slow_mode = 0;
  logic [3:0] cfg_float_cycles = 0;
  logic reload_pulse;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_gap_sequencer #(.NUM_CS(4), .FLOAT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_write(req_write), .req_internal(req_internal), .req_ready(req_ready),
    .xfer_done(xfer_done), .cfg_mode_wr(cfg_mode_wr), .cfg_timing_wr(cfg_timing_wr),
    .cfg_cs(cfg_cs), .cfg_float_cycles(cfg_float_cycles), .cfg_float_mode(cfg_float_mode),
    .slow_mode(slow_mode), .reload_pulse(reload_pulse));

  // fields: [11:10] cs, [9] write, [8] internal, [7:5] gap, [4] pulses, [3:0] requirement
  localparam logic [11:0] VEC [10] = '{
    {2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},  // R1 first access free
    {2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 same cs read-read
    {2'd0, 1'b1, 1'b0, 3'd1, 1'b0, 4'd6},  // R6 read then write
    {2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 write-write same cs
    {2'd1, 1'b1, 1'b0, 3'd1, 1'b0, 4'd5},  // R5 cs change
    {2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 write then read free
    {2'd2, 1'b1, 1'b0, 3'd2, 1'b0, 4'd6},  // R6 cs change plus read-write
    {2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5
    {2'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd10}, // R10 internal
    {2'd2, 1'b1, 1'b0, 3'd1, 1'b0, 4'd10}  // R10 internal not the previous access
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    req_valid = 0; xfer_done = 0; cfg_mode_wr = 0; cfg_timing_wr = 0; slow_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "reload_pulse at reset", reload_pulse, 0);
    check("R1", "req_ready idle at reset", req_ready, 0);
    @(negedge clk);
  endtask

  task automatic access(input int cs, input int wr, input int intl, input int expg, input int expp, input string req);
    int k = 0, p = 0;
    bit got = 0;
    req_cs = cs[1:0]; req_write = wr[0]; req_internal = intl[0]; req_valid = 1;
    while (!got && k < 40) begin
      #1;
      if (reload_pulse) p++;
      if (req_ready) got = 1;
      else begin @(negedge clk); k++; end
    end
    @(negedge clk);
    req_valid = 0; req_internal = 0;
    check(req, "gap", k, expg);
    check(req, "reload pulses", p, expp);
  endtask

  task automatic finish_xfer();
    @(negedge clk);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic mode_wr(input int cs, input int flt, input int md);
    cfg_cs = cs[1:0]; cfg_float_cycles = flt[3:0]; cfg_float_mode = md[0]; cfg_mode_wr = 1;
    @(negedge clk);
    cfg_mode_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
      if (!VEC[i][8]) finish_xfer();
    end

    do_reset();
    access(0, 0, 0, 0, 0, "R1"); finish_xfer();
    cfg_timing_wr = 1; @(negedge clk); cfg_timing_wr = 0;
    access(0, 0, 0, 0, 0, "R2"); finish_xfer();
    mode_wr(3, 0, 0);
    access(0, 0, 0, 1, 1, "R3"); finish_xfer();
    mode_wr(0, 0, 0);
    access(1, 0, 0, 1, 1, "R4"); finish_xfer();
    mode_wr(2, 0, 0);
    access(1, 1, 0, 2, 1, "R3 R6 R12"); finish_xfer();

    // R7: slow mode change during a transfer, R11 busy holds the grant
    access(1, 0, 0, 0, 0, "R7");
    slow_mode = 1;
    req_cs = 1; req_write = 0; req_internal = 0; req_valid = 1;
    #1;
    check("R7", "pulse during transfer", reload_pulse, 0);
    check("R11", "ready during transfer", req_ready, 0);
    req_internal = 1;
    #1;
    check("R10", "internal ready during transfer", req_ready, 1);
    @(negedge clk);
    req_valid = 0; req_internal = 0;
    finish_xfer();
    access(1, 0, 0, 1, 1, "R7"); finish_xfer();

    // R8: float count 5 on cs1
    mode_wr(1, 5, 0);
    access(1, 0, 0, 1, 1, "R8 R9"); finish_xfer();
    access(2, 0, 0, 5, 0, "R8 read to other cs"); finish_xfer();
    access(2, 1, 0, 1, 0, "R8 zero count"); finish_xfer();
    access(1, 0, 0, 1, 0, "R5"); finish_xfer();
    access(1, 1, 0, 5, 0, "R8 write after read"); finish_xfer();

    // R9: float mode on cs1
    mode_wr(1, 3, 1);
    access(1, 0, 0, 1, 1, "R9"); finish_xfer();
    access(1, 0, 0, 3, 0, "R9 mode set"); finish_xfer();
    mode_wr(1, 3, 0);
    access(1, 0, 0, 1, 1, "R9"); finish_xfer();
    access(1, 0, 0, 0, 0, "R9 mode clear"); finish_xfer();

    // R10: internal access during float; it consumes one of the 3 float cycles
    access(0, 0, 1, 0, 0, "R10");
    access(1, 1, 0, 2, 0, "R10 R8"); finish_xfer();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule